// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Meter

This block measures the frequency of one internal clock against the block's own reference clock. The reference clock also runs the register interface. Software first picks a clock from one of two source groups and chooses whether that clock is halved before counting. It then sets the window length in reference cycles, enables the meter and sets the trigger bit. For as long as the window is open, the block counts rising edges of the selected clock. When the count is final, the hardware clears the trigger bit and the count becomes readable. With a 26 MHz reference and a 1024-cycle window, software converts the count to kHz as count × 26000 / 1024.

Window start and window end cross into the measured clock domain through two-flop synchronisers. The measured domain sends its synchronised gate back as an acknowledge, which is synchronised the same way. The reference domain copies the count only after that acknowledge has fallen, and by then the edge counter has stopped. If the selected clock is not running, the trigger bit stays set, and software treats the result as invalid after its own timeout.

Top module: `refwin_fmeter`

## Requirements
- R1: After reset, all four registers (word index 0 source select, 1 divider, 2 control, 3 window/count) read 0, so the trigger bit reads 0.
- R2: Bits 1:0 of the word-0 register choose the source: 0 selects group A, indexed by bits 21:16, and 1 selects group B, indexed by bits 13:8. The other group's index has no effect on the measurement.
- R3: Bits 31:24 of the word-1 register set the divider. The value 1 halves the selected clock before counting. Every other value, including 0 and 5, passes it through undivided.
- R4: Writing word 2 with bit 12 (enable) and bit 4 (trigger) both 1 while idle starts a measurement. Bit 4 then reads 1 until the result is available, and the hardware returns it to 0.
- R5: The gate stays open for L+1 reference cycles, where L is bits 25:16 of word 3. The captured count equals the number of counted clock edges in that window, within ±2.
- R6: The count reads from bits 15:0 of word 3. It changes only when a measurement completes, and it keeps its value while the next measurement is running.
- R7: The edge counter saturates at its all-ones value and does not wrap.
- R8: A write to word 2 with bit 4 set and bit 12 clear starts nothing: bit 4 keeps reading 0.
- R9: A second trigger write while a measurement is running is ignored. The measurement ends at the time set by the first trigger and gives the count from that first window.
- R10: Writing bit 12 to 0 during a measurement aborts it. Bit 4 reads 0 and the count keeps its previous value.
- R11: Fields read back as written, and bits that belong to no field read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the register interface |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously to clk |
| clk_grp_a | input | NUM_A | Group A clocks to be measured |
| clk_grp_b | input | NUM_B | Group B clocks to be measured |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
The assertions check on every cycle that the gate stays open for exactly L+1 reference cycles, that the trigger bit rises only after a qualifying write, and that clearing enable drops it. They also check that the captured count changes only as a measurement completes, and that the measured-domain counter holds at all-ones. Only the bench's scenarios can show that the counts are right for each source, group and divider setting, since that depends on the real ratio between the clocks. The same holds for the timing of an ignored second trigger and for the count surviving an abort.

// File: rtl/fmeter_pkg.sv
`timescale 1ns/1ps
package fmeter_pkg;
  // Register word indices
  localparam logic [1:0] OFS_SEL = 2'd0;
  localparam logic [1:0] OFS_DIV = 2'd1;
  localparam logic [1:0] OFS_CTL = 2'd2;
  localparam logic [1:0] OFS_WIN = 2'd3;

  localparam int CTL_EN_BIT   = 12;
  localparam int CTL_TRIG_BIT = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_OPEN  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [5:0] sel_a;
    logic [5:0] sel_b;
    logic [1:0] src;
    logic [7:0] div;
  } meter_cfg_t;
endpackage

// File: rtl/fmeter_regs.sv
`timescale 1ns/1ps
module fmeter_regs
  import fmeter_pkg::*;
#(
  parameter int LOAD_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              capture,
  input  logic [CNT_W-1:0]  meas_count,
  output logic [31:0]       rdata,
  output meter_cfg_t        cfg,
  output logic              en,
  output logic [LOAD_W-1:0] load,
  output logic [CNT_W-1:0]  count,
  output logic              start_req
);
  meter_cfg_t        cfg_q, cfg_d;
  logic              en_q, en_d;
  logic [LOAD_W-1:0] load_q, load_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[23:22], wdata[15:14], wdata[7:5], wdata[3:2]};

  always_comb begin
    cfg_d   = cfg_q;
    en_d    = en_q;
    load_d  = load_q;
    count_d = capture ? meas_count : count_q;
    if (wr) begin
      case (addr)
        OFS_SEL: begin
          cfg_d.sel_a = wdata[21:16];
          cfg_d.sel_b = wdata[13:8];
          cfg_d.src   = wdata[1:0];
        end
        OFS_DIV: cfg_d.div = wdata[31:24];
        OFS_CTL: en_d = wdata[CTL_EN_BIT];
        default: load_d = wdata[16 +: LOAD_W];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      en_q    <= 1'b0;
      load_q  <= '0;
      count_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      en_q    <= en_d;
      load_q  <= load_d;
      count_q <= count_d;
    end
  end

  assign start_req = wr && (addr == OFS_CTL) && wdata[CTL_EN_BIT] && wdata[CTL_TRIG_BIT];

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_SEL: begin
        rdata[21:16] = cfg_q.sel_a;
        rdata[13:8]  = cfg_q.sel_b;
        rdata[1:0]   = cfg_q.src;
      end
      OFS_DIV: rdata[31:24] = cfg_q.div;
      OFS_CTL: begin
        rdata[CTL_EN_BIT]   = en_q;
        rdata[CTL_TRIG_BIT] = busy;
      end
      default: begin
        rdata[16 +: LOAD_W] = load_q;
        rdata[CNT_W-1:0]    = count_q;
      end
    endcase
  end

  assign cfg   = cfg_q;
  assign en    = en_q;
  assign load  = load_q;
  assign count = count_q;
endmodule

// File: rtl/fmeter_clksel.sv
`timescale 1ns/1ps
module fmeter_clksel #(
  parameter int NUM_A = 4,
  parameter int NUM_B = 4
) (
  input  logic             rst_n,
  input  logic [NUM_A-1:0] clk_a,
  input  logic [NUM_B-1:0] clk_b,
  input  logic [5:0]       sel_a,
  input  logic [5:0]       sel_b,
  input  logic [1:0]       src,
  input  logic [7:0]       div,
  output logic             mclk
);
  logic pick_a, pick_b, raw_clk, half_q;

  always_comb begin
    pick_a = 1'b0;
    for (int i = 0; i < NUM_A; i++)
      if (sel_a == 6'(i)) pick_a = clk_a[i];
  end

  always_comb begin
    pick_b = 1'b0;
    for (int i = 0; i < NUM_B; i++)
      if (sel_b == 6'(i)) pick_b = clk_b[i];
  end

  always_comb begin
    case (src)
      2'd0:    raw_clk = pick_a;
      2'd1:    raw_clk = pick_b;
      default: raw_clk = 1'b0;
    endcase
  end

  // Divide-by-two toggle stage
  always_ff @(posedge raw_clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign mclk = (div == 8'd1) ? half_q : raw_clk;
endmodule

// File: rtl/fmeter_window.sv
`timescale 1ns/1ps
module fmeter_window
  import fmeter_pkg::*;
#(
  parameter int LOAD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              en,
  input  logic [LOAD_W-1:0] load,
  input  logic              ack_async,
  output logic              gate,
  output logic              busy,
  output logic              capture
);
  seq_state_e        state_q, state_d;
  logic [LOAD_W-1:0] win_q, win_d;
  logic              seen_q, seen_d;
  logic              ack_s1, ack_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_async;
      ack_s2 <= ack_s1;
    end
  end

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    seen_d  = seen_q;
    capture = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_req && !ack_s2) begin
          state_d = SEQ_OPEN;
          win_d   = load;
          seen_d  = 1'b0;
        end
      end
      SEQ_OPEN: begin
        if (!en) begin
          state_d = SEQ_IDLE;
        end else begin
          if (ack_s2) seen_d = 1'b1;
          if (win_q == '0) state_d = SEQ_DRAIN;
          else             win_d   = win_q - LOAD_W'(1);
        end
      end
      SEQ_DRAIN: begin
        if (!en) begin
          state_d = SEQ_IDLE;
        end else begin
          if (ack_s2) seen_d = 1'b1;
          if (seen_q && !ack_s2) begin
            capture = 1'b1;
            state_d = SEQ_IDLE;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      win_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      seen_q  <= seen_d;
    end
  end

  assign gate = (state_q == SEQ_OPEN);
  assign busy = (state_q != SEQ_IDLE);
endmodule

// File: rtl/fmeter_edgecnt.sv
`timescale 1ns/1ps
module fmeter_edgecnt #(
  parameter int CNT_W = 16
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             gate,
  output logic [CNT_W-1:0] cnt,
  output logic             ack
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       rs_q;
  logic             mrst_n;
  logic             g_s1, g_s2, g_s3;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Local reset, released synchronously to the measured clock
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign mrst_n = rs_q[1];

  always_comb begin
    cnt_d = cnt_q;
    if (g_s2 && !g_s3)                cnt_d = CNT_W'(1);
    else if (g_s2 && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge mclk or negedge mrst_n) begin
    if (!mrst_n) begin
      g_s1  <= 1'b0;
      g_s2  <= 1'b0;
      g_s3  <= 1'b0;
      cnt_q <= '0;
    end else begin
      g_s1  <= gate;
      g_s2  <= g_s1;
      g_s3  <= g_s2;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
  assign ack = g_s2;
endmodule

// File: rtl/refwin_fmeter.sv
`timescale 1ns/1ps
module refwin_fmeter
  import fmeter_pkg::*;
#(
  parameter int NUM_A  = 4,
  parameter int NUM_B  = 4,
  parameter int LOAD_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_A-1:0] clk_grp_a,
  input  logic [NUM_B-1:0] clk_grp_b,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata
);
  meter_cfg_t        cfg;
  logic              en, start_req, busy, gate, capture, mclk, ack;
  logic [LOAD_W-1:0] load;
  logic [CNT_W-1:0]  count, mcnt;

  fmeter_regs #(.LOAD_W(LOAD_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .capture(capture), .meas_count(mcnt), .rdata(reg_rdata),
    .cfg(cfg), .en(en), .load(load), .count(count), .start_req(start_req)
  );

  fmeter_clksel #(.NUM_A(NUM_A), .NUM_B(NUM_B)) u_clksel (
    .rst_n(rst_n), .clk_a(clk_grp_a), .clk_b(clk_grp_b), .sel_a(cfg.sel_a),
    .sel_b(cfg.sel_b), .src(cfg.src), .div(cfg.div), .mclk(mclk)
  );

  fmeter_window #(.LOAD_W(LOAD_W)) u_window (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .en(en), .load(load),
    .ack_async(ack), .gate(gate), .busy(busy), .capture(capture)
  );

  fmeter_edgecnt #(.CNT_W(CNT_W)) u_edgecnt (
    .mclk(mclk), .rst_n(rst_n), .gate(gate), .cnt(mcnt), .ack(ack)
  );
endmodule

// File: rtl/fmeter_chk.sv
`timescale 1ns/1ps
module fmeter_chk #(
  parameter int LOAD_W = 10,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mclk,
  input logic              gate,
  input logic              busy,
  input logic              en,
  input logic              start_req,
  input logic [LOAD_W-1:0] load,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  mcnt
);
  logic [LOAD_W:0]   len_q;
  logic [LOAD_W-1:0] wload_q;
  logic              gate_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      wload_q <= '0;
      gate_d  <= 1'b0;
    end else begin
      gate_d <= gate;
      len_q  <= gate ? len_q + (LOAD_W+1)'(1) : '0;
      if (gate && !gate_d) wload_q <= load;
    end
  end

  a_r4_rise_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));

  a_r5_window_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate) && en) |-> (len_q == (LOAD_W+1)'(wload_q) + (LOAD_W+1)'(1)));

  a_r6_count_on_completion: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> ($past(busy) && !busy));

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !start_req) |=> !busy);

  a_r7_saturate: assert property (@(posedge mclk) disable iff (!rst_n)
    (mcnt == '1) |=> ((mcnt == '1) || (mcnt == CNT_W'(1))));
endmodule

bind refwin_fmeter fmeter_chk #(.LOAD_W(LOAD_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mclk(mclk), .gate(gate), .busy(busy), .en(en),
  .start_req(start_req), .load(load), .count(count), .mcnt(mcnt)
);

// File: tb/refwin_fmeter_tb.sv
`timescale 1ns/1ps
module refwin_fmeter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_sat;
  logic [3:0]  ga, gb;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz reference

  // Group clocks: half periods A {1.0,1.6,4.0,3.2} ns, B {0.8,2.0,1.2,5.0} ns
  for (genvar i = 0; i < 4; i++) begin : g_clk
    localparam real HA = (i == 0) ? 1.0 : (i == 1) ? 1.6 : (i == 2) ? 4.0 : 3.2;
    localparam real HB = (i == 0) ? 0.8 : (i == 1) ? 2.0 : (i == 2) ? 1.2 : 5.0;
    logic ca = 1'b0;
    logic cb = 1'b0;
    initial begin #0.3; forever #(HA) ca = ~ca; end
    initial begin #0.7; forever #(HB) cb = ~cb; end
    assign ga[i] = ca;
    assign gb[i] = cb;
  end

  refwin_fmeter dut_i (
    .clk(clk), .rst_n(rst_n), .clk_grp_a(ga), .clk_grp_b(gb),
    .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
  );

  refwin_fmeter #(.CNT_W(8)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .clk_grp_a(ga), .clk_grp_b(gb),
    .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata_sat)
  );

  // {src[1:0], sel[5:0], div[7:0], load[9:0], expected[15:0]}
  localparam logic [41:0] VEC [8] = '{
    {2'd0, 6'd0, 8'd0, 10'd99,   16'd200},
    {2'd0, 6'd1, 8'd0, 10'd199,  16'd250},
    {2'd0, 6'd2, 8'd1, 10'd399,  16'd100},
    {2'd0, 6'd3, 8'd0, 10'd15,   16'd10},
    {2'd1, 6'd0, 8'd1, 10'd1023, 16'd1280},
    {2'd1, 6'd1, 8'd0, 10'd0,    16'd1},
    {2'd1, 6'd2, 8'd0, 10'd299,  16'd500},
    {2'd1, 6'd3, 8'd1, 10'd499,  16'd100}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d, output logic [31:0] ds);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
    ds = rdata_sat;
  endtask

  task automatic setup(input int src, input int sel, input int div, input int load);
    logic [5:0] s, decoy;
    s = 6'(sel);
    decoy = 6'(3 - sel);
    if (src == 0) bus_write(2'd0, {10'd0, s, 2'd0, decoy, 6'd0, 2'd0});
    else          bus_write(2'd0, {10'd0, decoy, 2'd0, s, 6'd0, 2'd1});
    bus_write(2'd1, {8'(div), 24'd0});
    bus_write(2'd3, {6'd0, 10'(load), 16'd0});
    bus_write(2'd2, 32'h0000_1000);
  endtask

  task automatic wait_done(output int cyc);
    logic [31:0] v, vs;
    cyc = 0;
    do begin
      bus_read(2'd2, v, vs);
      cyc++;
    end while ((v[4] || vs[4]) && cyc < 4000);
  endtask

  function automatic int absdiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] v, vs;
    int cyc, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), v, vs);
      chk(v == 32'd0, "R1 reset value", int'(v), 0);
    end

    // R11: readback with unused bits zero
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, v, vs);
    chk(v == 32'h003F_3F03, "R11 select readback", int'(v), 32'h003F_3F03);
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, v, vs);
    chk(v == 32'hFF00_0000, "R11 divider readback", int'(v), 32'hFF00_0000);
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd3, v, vs);
    chk(v == 32'h03FF_0000, "R11 window readback", int'(v), 32'h03FF_0000);

    // R8: trigger without enable is ignored
    bus_write(2'd2, 32'h0000_0010);
    bus_read(2'd2, v, vs);
    chk(v == 32'd0, "R8 trigger without enable", int'(v), 0);
    repeat (20) @(negedge clk);
    bus_read(2'd3, v, vs);
    chk(v[15:0] == 16'd0, "R8 count untouched", int'(v[15:0]), 0);

    // R2 R3 R4 R5: table of measurements
    for (int k = 0; k < 8; k++) begin
      setup(int'(VEC[k][41:40]), int'(VEC[k][39:34]), int'(VEC[k][33:26]), int'(VEC[k][25:16]));
      bus_write(2'd2, 32'h0000_1010);
      bus_read(2'd2, v, vs);
      chk(v[4] == 1'b1, "R4 trigger reads busy", int'(v[4]), 1);
      wait_done(cyc);
      chk(cyc < 4000, "R4 trigger self-clears", cyc, 0);
      bus_read(2'd3, v, vs);
      chk(absdiff(int'(v[15:0]), int'(VEC[k][15:0])) <= 2, "R2 R3 R5 count", int'(v[15:0]), int'(VEC[k][15:0]));
      if (k == 4) chk(vs[7:0] == 8'hFF, "R7 saturation", int'(vs[7:0]), 255);
      if (k == 0) chk(absdiff(int'(vs[7:0]), 200) <= 2, "R7 below limit", int'(vs[7:0]), 200);
    end

    // R3: divider value other than 1 passes through
    setup(0, 0, 5, 99);
    bus_write(2'd2, 32'h0000_1010);
    wait_done(cyc);
    bus_read(2'd3, v, vs);
    chk(absdiff(int'(v[15:0]), 200) <= 2, "R3 divider 5 passes through", int'(v[15:0]), 200);
    prev = int'(v[15:0]);

    // R6: count held during next measurement, then updated and stable
    setup(0, 2, 1, 1023);
    bus_write(2'd2, 32'h0000_1010);
    repeat (500) @(negedge clk);
    bus_read(2'd3, v, vs);
    chk(int'(v[15:0]) == prev, "R6 count held mid-window", int'(v[15:0]), prev);
    wait_done(cyc);
    bus_read(2'd3, v, vs);
    chk(absdiff(int'(v[15:0]), 256) <= 2, "R6 new count", int'(v[15:0]), 256);
    prev = int'(v[15:0]);
    repeat (50) @(negedge clk);
    bus_read(2'd3, v, vs);
    chk(int'(v[15:0]) == prev, "R6 count stays", int'(v[15:0]), prev);

    // R9: second trigger during measurement ignored
    setup(0, 0, 0, 1023);
    bus_write(2'd2, 32'h0000_1010);
    repeat (300) @(negedge clk);
    bus_write(2'd2, 32'h0000_1010);
    wait_done(cyc);
    chk(cyc < 1024 - 300 + 40, "R9 ends on first window", cyc, 724);
    bus_read(2'd3, v, vs);
    chk(absdiff(int'(v[15:0]), 2048) <= 2, "R9 count of first window", int'(v[15:0]), 2048);
    prev = int'(v[15:0]);

    // R10: disable aborts, count unchanged
    setup(0, 2, 1, 1023);
    bus_write(2'd2, 32'h0000_1010);
    repeat (100) @(negedge clk);
    bus_write(2'd2, 32'h0000_0000);
    repeat (2) @(negedge clk);
    bus_read(2'd2, v, vs);
    chk(v[4] == 1'b0, "R10 abort clears trigger", int'(v[4]), 0);
    repeat (1200) @(negedge clk);
    bus_read(2'd3, v, vs);
    chk(int'(v[15:0]) == prev, "R10 count kept after abort", int'(v[15:0]), prev);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule